// File: doc/BRIEF.md
# Shared-Divider Event Counter and Watchdog

This block pairs an 8-bit event counter with an 8-bit watchdog, and the two share one 8-bit binary divider. A configuration byte sets where the divider sits. In counter mode it stands in front of the event counter as a prescaler. In watchdog mode it stands behind the watchdog and counts watchdog wraps before a timeout is raised. The same byte also selects the counter's clock source, the edge polarity of the external pin and the divide ratio.

The counter advances on instruction-cycle enables or on edges of a synchronised external pin. When it wraps from FFh to 00h it raises a one-cycle interrupt request, unless that request is masked. The watchdog counts ticks from an outside slow oscillator and raises a one-cycle timeout pulse. A clear strobe and a sleep strobe both restart the watchdog. A configuration input can lock the two top configuration bits: while it is set they read back as 1 and keep their inactive meaning.

Top module: `shared_div_timer`

## Requirements
- R1: After reset the configuration byte reads FFh, `cnt_o` is 00h, `irq_o` and `wdt_to_o` are low and `map_sel_o` is 1.
- R2: Configuration layout: bit 7 masks the interrupt (1 = masked), bit 6 drives `map_sel_o`, bit 5 picks the source (0 = `cyc_en_i`, 1 = pin), bit 4 picks the pin edge (0 = rising, 1 = falling), bit 3 picks the divider owner (0 = counter, 1 = watchdog), bits 2:0 hold the rate n. While `ext_cfg_i` is 1, bits 7 and 6 read back as 1, the interrupt stays masked and `map_sel_o` is 1. The written values return once `ext_cfg_i` is 0.
- R3: With the divider owned by the counter, the counter advances once per 2^(n+1) source events after the divider was last cleared. It never steps by more than one.
- R4: With the pin source, the counter counts only the selected edge of `ext_pin_i`, after a two-stage synchroniser, and ignores `cyc_en_i`.
- R5: A counter wrap from FFh to 00h gives `irq_o` high for one cycle, in the cycle after the wrapping edge, only when bit 7 is 0.
- R6: With the divider owned by the counter, `wdt_to_o` pulses for one cycle after every 256th watchdog tick since the last clear.
- R7: With the divider owned by the watchdog, `wdt_to_o` pulses after every 2^n watchdog wraps, that is every 256*2^n ticks since the last clear.
- R8: `wdt_clr_i` restarts the watchdog. It clears the divider only when the watchdog owns it, so a counter prescale in progress is kept.
- R9: `sleep_i` has the same effect as `wdt_clr_i`: the watchdog loads 00h, and the divider clears when the watchdog owns it.
- R10: Every configuration write clears the divider.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_cfg_i | input | 1 | Locks configuration bits 7 and 6 to 1 |
| opt_wr_i | input | 1 | Configuration write strobe |
| opt_wdata_i | input | 8 | Configuration write data |
| opt_rdata_o | output | 8 | Configuration read-back |
| cyc_en_i | input | 1 | Instruction-cycle enable, internal counter source |
| ext_pin_i | input | 1 | Asynchronous external count pin |
| wdt_tick_i | input | 1 | Watchdog oscillator tick, one cycle wide |
| wdt_clr_i | input | 1 | Watchdog clear strobe |
| sleep_i | input | 1 | Sleep strobe |
| cnt_o | output | 8 | Event counter value |
| irq_o | output | 1 | Counter wrap interrupt pulse |
| wdt_to_o | output | 1 | Watchdog timeout pulse |
| map_sel_o | output | 1 | Effective value of configuration bit 6 |

## Verification
A wrong divider value or width shows up on the ports within one prescale period. `cnt_o` then steps on the wrong source event, or a timeout lands at the wrong tick. Those are measured against the cycle at which the bench predicts them. A missed clear on a clear, sleep or configuration write shifts the next counter step or timeout by a whole number of source events. A wrong mask or lock path shows up as an extra or missing interrupt at the next counter wrap. The scoreboard pairs each predicted pulse with the exact cycle in which it should appear, so both an early pulse and a late pulse are reported.

// File: rtl/sdt_pkg.sv
package sdt_pkg;
  localparam int OPT_W  = 8;
  localparam int RATE_W = 3;

  typedef struct packed {
    logic              irq_mask;
    logic              map_sel;
    logic              src_ext;
    logic              edge_fall;
    logic              div_to_wdt;
    logic [RATE_W-1:0] rate;
  } opt_t;

  localparam logic [OPT_W-1:0] OPT_RST = 8'hFF;
endpackage

// File: rtl/sdt_option.sv
module sdt_option
  import sdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [OPT_W-1:0] wdata_i,
  input  logic             ext_cfg_i,
  output opt_t             opt_o,
  output logic [OPT_W-1:0] rdata_o
);
  logic [OPT_W-1:0] opt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   opt_q <= OPT_RST;
    else if (wr_i) opt_q <= wdata_i;
  end

  // locked top bits read as ones and keep their inactive meaning
  assign rdata_o = ext_cfg_i ? {2'b11, opt_q[OPT_W-3:0]} : opt_q;
  assign opt_o   = opt_t'(rdata_o);
endmodule

// File: rtl/sdt_edge_sync.sv
module sdt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic fall_i,
  output logic evt_o
);
  logic [STAGES:0] sh_q;

  generate
    for (genvar i = 0; i <= STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sh_q[0] <= 1'b0;
          else         sh_q[0] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sh_q[i] <= 1'b0;
          else         sh_q[i] <= sh_q[i-1];
        end
      end
    end
  endgenerate

  logic cur, prev;
  assign cur   = sh_q[STAGES-1];
  assign prev  = sh_q[STAGES];
  assign evt_o = fall_i ? (prev & ~cur) : (cur & ~prev);
endmodule

// File: rtl/sdt_divider.sv
module sdt_divider #(
  parameter int DIV_W  = 8,
  parameter int RATE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              post_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic              evt_i,
  output logic              tick_o
);
  logic [DIV_W-1:0] div_q;
  logic [RATE_W:0]  nbits;
  logic [DIV_W:0]   full;
  logic [DIV_W-1:0] mask;

  // prescale uses n+1 bits, postscale uses n bits
  assign nbits  = {1'b0, rate_i} + {{RATE_W{1'b0}}, ~post_i};
  assign full   = ((DIV_W+1)'(1) << nbits) - (DIV_W+1)'(1);
  assign mask   = full[DIV_W-1:0];
  assign tick_o = evt_i & ~clr_i & (&(div_q | ~mask));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (clr_i)  div_q <= '0;
    else if (evt_i)  div_q <= div_q + 1'b1;
  end

  AST_DIV_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> div_q == '0); // R10
endmodule

// File: rtl/sdt_wdog.sv
module sdt_wdog #(
  parameter int WDT_W = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  output logic ovf_o
);
  logic [WDT_W-1:0] wdt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      wdt_q <= '0;
    else if (clr_i)   wdt_q <= '0;
    else if (tick_i)  wdt_q <= wdt_q + 1'b1;
  end

  assign ovf_o = tick_i & ~clr_i & (&wdt_q);

  AST_WDT_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> wdt_q == '0); // R9
endmodule

// File: rtl/shared_div_timer.sv
module shared_div_timer
  import sdt_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int WDT_W       = 8,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_cfg_i,
  input  logic             opt_wr_i,
  input  logic [OPT_W-1:0] opt_wdata_i,
  output logic [OPT_W-1:0] opt_rdata_o,
  input  logic             cyc_en_i,
  input  logic             ext_pin_i,
  input  logic             wdt_tick_i,
  input  logic             wdt_clr_i,
  input  logic             sleep_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o,
  output logic             wdt_to_o,
  output logic             map_sel_o
);
  opt_t opt;
  logic pin_evt, src_evt, wd_clr, wdt_ovf;
  logic div_evt, div_clr, div_tick, cnt_inc, timeout;
  logic [CNT_W-1:0] cnt_q;
  logic irq_q, to_q;

  sdt_option u_option (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (opt_wr_i),
    .wdata_i (opt_wdata_i),
    .ext_cfg_i(ext_cfg_i),
    .opt_o   (opt),
    .rdata_o (opt_rdata_o)
  );

  sdt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (ext_pin_i),
    .fall_i (opt.edge_fall),
    .evt_o  (pin_evt)
  );

  assign src_evt = opt.src_ext ? pin_evt : cyc_en_i;
  assign wd_clr  = wdt_clr_i | sleep_i;

  sdt_wdog #(.WDT_W(WDT_W)) u_wdog (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (wdt_tick_i),
    .clr_i  (wd_clr),
    .ovf_o  (wdt_ovf)
  );

  assign div_evt = opt.div_to_wdt ? wdt_ovf : src_evt;
  assign div_clr = opt_wr_i | (wd_clr & opt.div_to_wdt);

  sdt_divider #(.DIV_W(DIV_W), .RATE_W(RATE_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (div_clr),
    .post_i (opt.div_to_wdt),
    .rate_i (opt.rate),
    .evt_i  (div_evt),
    .tick_o (div_tick)
  );

  assign cnt_inc = opt.div_to_wdt ? src_evt : div_tick;
  assign timeout = opt.div_to_wdt ? div_tick : wdt_ovf;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
      to_q  <= 1'b0;
    end else begin
      if (cnt_inc) cnt_q <= cnt_q + 1'b1;
      irq_q <= cnt_inc & (&cnt_q) & ~opt.irq_mask;
      to_q  <= timeout;
    end
  end

  assign cnt_o     = cnt_q;
  assign irq_o     = irq_q;
  assign wdt_to_o  = to_q;
  assign map_sel_o = opt.map_sel;

  AST_CNT_SINGLE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cnt_q) |-> cnt_q == $past(cnt_q) + 1'b1); // R3
  AST_IRQ_AT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> cnt_q == '0); // R5
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o); // R5
  AST_TO_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_to_o |=> !wdt_to_o); // R6
endmodule

// File: tb/shared_div_timer_bench.sv
module shared_div_timer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC    = 150000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ext_cfg_i = 1'b0;
  logic       opt_wr_i = 1'b0;
  logic [7:0] opt_wdata_i = '0;
  logic [7:0] opt_rdata_o;
  logic       cyc_en_i = 1'b0;
  logic       ext_pin_i = 1'b0;
  logic       wdt_tick_i = 1'b0;
  logic       wdt_clr_i = 1'b0;
  logic       sleep_i = 1'b0;
  logic [7:0] cnt_o;
  logic       irq_o, wdt_to_o, map_sel_o;

  shared_div_timer u_shared_div_timer (
    .clk_i, .rst_ni, .ext_cfg_i, .opt_wr_i, .opt_wdata_i, .opt_rdata_o,
    .cyc_en_i, .ext_pin_i, .wdt_tick_i, .wdt_clr_i, .sleep_i,
    .cnt_o, .irq_o, .wdt_to_o, .map_sel_o
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  int q_to[$];
  int q_irq[$];
  int e_to, e_irq;

  // model state
  int m_cnt = 0, m_bd = 0, m_bw = 0, m_rate = 7;
  bit m_wdt = 1, m_mask = 1;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk_i) if (rst_ni) begin
    if (wdt_to_o) begin
      n_chk++;
      if (q_to.size() == 0) begin
        n_fail++; $display("FAIL R6 R7 actual=timeout@%0d expected=none", cyc);
      end else begin
        e_to = q_to.pop_front();
        if (e_to != cyc) begin
          n_fail++; $display("FAIL R6 R7 actual=timeout@%0d expected=@%0d", cyc, e_to);
        end
      end
    end
    if (irq_o) begin
      n_chk++;
      if (q_irq.size() == 0) begin
        n_fail++; $display("FAIL R5 actual=irq@%0d expected=none", cyc);
      end else begin
        e_irq = q_irq.pop_front();
        if (e_irq != cyc) begin
          n_fail++; $display("FAIL R5 actual=irq@%0d expected=@%0d", cyc, e_irq);
        end
      end
    end
  end

  task automatic wr_opt(input logic [7:0] d);
    opt_wr_i = 1'b1; opt_wdata_i = d;
    @(negedge clk_i);
    opt_wr_i = 1'b0;
    m_bd = 0;
    m_wdt = d[3];
    m_rate = int'(d[2:0]);
    m_mask = d[7] | ext_cfg_i;
  endtask

  task automatic strobe(input bit slp);
    if (slp) sleep_i = 1'b1; else wdt_clr_i = 1'b1;
    @(negedge clk_i);
    sleep_i = 1'b0; wdt_clr_i = 1'b0;
    m_bw = 0;
    if (m_wdt) m_bd = 0;
  endtask

  task automatic run_cnt(input int n);
    for (int i = 0; i < n; i++) begin
      bit inc;
      cyc_en_i = 1'b1;
      if (m_wdt) inc = 1;
      else begin
        m_bd++;
        inc = (m_bd % (1 << (m_rate + 1))) == 0;
      end
      if (inc) begin
        m_cnt = (m_cnt + 1) % 256;
        if (m_cnt == 0 && !m_mask) q_irq.push_back(cyc + 1);
      end
      @(negedge clk_i);
    end
    cyc_en_i = 1'b0;
  endtask

  task automatic run_wdt(input int n);
    for (int i = 0; i < n; i++) begin
      wdt_tick_i = 1'b1;
      m_bw++;
      if (m_bw == 256) begin
        m_bw = 0;
        if (m_wdt) begin
          m_bd++;
          if ((m_bd % (1 << m_rate)) == 0) q_to.push_back(cyc + 1);
        end else q_to.push_back(cyc + 1);
      end
      @(negedge clk_i);
    end
    wdt_tick_i = 1'b0;
  endtask

  task automatic pin_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      ext_pin_i = 1'b1; repeat (3) @(negedge clk_i);
      ext_pin_i = 1'b0; repeat (3) @(negedge clk_i);
    end
    repeat (4) @(negedge clk_i);
  endtask

  task automatic finish_run();
    foreach (q_to[i]) begin
      n_chk++; n_fail++;
      $display("FAIL R6 R7 actual=none expected=timeout@%0d", q_to[i]);
    end
    foreach (q_irq[i]) begin
      n_chk++; n_fail++;
      $display("FAIL R5 actual=none expected=irq@%0d", q_irq[i]);
    end
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (MAX_CYC) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk("R1 rdata", int'(opt_rdata_o), 8'hFF);
    chk("R1 cnt", int'(cnt_o), 0);
    chk("R1 irq", int'(irq_o), 0);
    chk("R1 to", int'(wdt_to_o), 0);
    chk("R1 map_sel", int'(map_sel_o), 1);

    // R3 R5: rate 0 prescale, unmasked, wraps once
    wr_opt(8'h00);
    chk("R2 map_sel", int'(map_sel_o), 0);
    chk("R2 rdata", int'(opt_rdata_o), 8'h00);
    run_cnt(600);
    @(negedge clk_i);
    chk("R3 cnt rate0", int'(cnt_o), m_cnt);

    // R3 R10: rate 2
    wr_opt(8'h02);
    run_cnt(35);
    @(negedge clk_i);
    chk("R3 cnt rate2", int'(cnt_o), m_cnt);

    // R5 masked wrap gives no interrupt
    wr_opt(8'h82);
    run_cnt(1700);
    @(negedge clk_i);
    chk("R5 cnt masked", int'(cnt_o), m_cnt);

    // R8 R9: clear and sleep keep counter prescale
    wr_opt(8'h01);
    run_cnt(2); strobe(0); run_cnt(2);
    @(negedge clk_i);
    chk("R8 prescale kept", int'(cnt_o), m_cnt);
    run_cnt(2); strobe(1); run_cnt(2);
    @(negedge clk_i);
    chk("R9 prescale kept", int'(cnt_o), m_cnt);

    // R10: rewrite clears divider
    wr_opt(8'h01);
    run_cnt(3);
    wr_opt(8'h01);
    run_cnt(3);
    @(negedge clk_i);
    chk("R10 no step", int'(cnt_o), m_cnt);
    run_cnt(1);
    @(negedge clk_i);
    chk("R10 step", int'(cnt_o), m_cnt);

    // R4 pin source, rising then falling, cyc_en ignored
    wr_opt(8'h20);
    cyc_en_i = 1'b1;
    pin_pulses(4);
    m_cnt = (m_cnt + 2) % 256;
    chk("R4 rising", int'(cnt_o), m_cnt);
    wr_opt(8'h30);
    pin_pulses(4);
    m_cnt = (m_cnt + 2) % 256;
    chk("R4 falling", int'(cnt_o), m_cnt);
    cyc_en_i = 1'b0;

    // R6: timeout every 256 ticks, divider on counter
    wr_opt(8'h80);
    strobe(0);
    run_wdt(600);
    repeat (2) @(negedge clk_i);
    chk("R6 pending", q_to.size(), 0);

    // R7: divider on watchdog, rate 1
    wr_opt(8'h89);
    strobe(0);
    run_wdt(1100);
    repeat (2) @(negedge clk_i);
    chk("R7 pending", q_to.size(), 0);

    // R8 R9 in watchdog mode: sleep clears partial postscale
    strobe(0);
    run_wdt(300);
    strobe(1);
    run_wdt(300);
    run_wdt(212);
    repeat (2) @(negedge clk_i);
    chk("R9 pending", q_to.size(), 0);
    chk("R8 cnt idle", int'(cnt_o), m_cnt);

    // R2 lock of top bits
    ext_cfg_i = 1'b1;
    @(negedge clk_i);
    chk("R2 locked rdata", int'(opt_rdata_o), 8'hC9);
    wr_opt(8'h00);
    chk("R2 locked read", int'(opt_rdata_o), 8'hC0);
    chk("R2 locked map_sel", int'(map_sel_o), 1);
    run_cnt(520);
    @(negedge clk_i);
    chk("R2 cnt locked", int'(cnt_o), m_cnt);
    chk("R2 irq quiet", q_irq.size(), 0);
    ext_cfg_i = 1'b0;
    @(negedge clk_i);
    chk("R2 unlocked read", int'(opt_rdata_o), 8'h00);
    chk("R2 unlocked map_sel", int'(map_sel_o), 0);

    repeat (3) @(negedge clk_i);
    finish_run();
  end
endmodule